// File: doc/BRIEF.md
# Dual-Rate Triple-Smoothed Drift Detector

This block watches a stream of mean path-latency figures, one value per measurement window, and decides whether recent behaviour has moved away from long-term behaviour. Every accepted sample feeds two smoothing channels that run side by side. Each channel is a cascade of three exponential moving averages. The slow channel uses a weight of 2^-10, so its output settles on the lifetime baseline without keeping any history. The fast channel uses a weight of about 0.8, so its output follows the latest windows closely.

When the fast result exceeds the slow result by more than a programmable threshold, a sticky warning flag is raised. The flag stays set until reset or an explicit clear. Samples are whole latency units. The smoothed results are signed fixed-point values with 12 fractional bits, so small corrections in the slow channel are not lost.

The three stages of a channel form a short pipeline. The results and the flag update together, a fixed number of cycles after each strobe, and a one-cycle marker pulse announces them.

Top module: `trend_drift_detector`

## Requirements
- R1: While reset is held and after it is released, out_valid and drift_flag are 0, and slow_trend and fast_trend read 0.
- R2: The first strobed sample after reset loads every stage of both channels with sample·2^12. The resulting report shows slow_trend = fast_trend = sample·2^12 and no flag.
- R3: Every later strobe updates each channel recursively: A ← A + g(sample·2^12 − A), then B ← B + g(A − B), then T ← T + g(B − T). Each stage uses the value its predecessor has just produced.
- R4: In the slow channel, g(d) is d arithmetically shifted right by 10 (floor division by 1024).
- R5: In the fast channel, g(d) is (d>>>1) + (d>>>2) + (d>>>5) + (d>>>6), with each term floored separately.
- R6: Take the clock edge that samples in_valid = 1. out_valid is high for exactly one cycle, after the third following edge. slow_trend and fast_trend change only on the edge that raises out_valid.
- R7: On the edge that raises out_valid, drift_flag is set if fast_trend − slow_trend (the values being reported) is strictly greater than thresh·2^12.
- R8: drift_flag stays set until reset or flag_clr. flag_clr clears it at the next edge, and it takes priority over a set condition on that same edge.
- R9: When the fast result lies at or below the slow result, drift_flag is not set, even with thresh = 0.
- R10: Strobes on consecutive cycles are accepted. Each one yields its own report on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe marking a new latency sample |
| in_sample | input | 16 | Mean latency of one window, unsigned whole units |
| thresh | input | 16 | Divergence limit in whole latency units |
| flag_clr | input | 1 | Clears the sticky warning flag |
| out_valid | output | 1 | One-cycle pulse marking fresh results |
| slow_trend | output | 30 | Slow-channel triple-smoothed value, signed, 12 fraction bits |
| fast_trend | output | 30 | Fast-channel triple-smoothed value, signed, 12 fraction bits |
| drift_flag | output | 1 | Sticky divergence warning |

## Verification
The assertions assume that thresh does not change between the edge that compares and the edge after it. They also assume that in_valid is low during reset, so any marker pulse can be traced back four edges to a real strobe. The stimulus changes thresh only together with a new strobe and holds it for the whole report. It keeps in_valid low during every reset. Sample values stay within 16 bits, which keeps every stage difference inside the signed state width. That is what the no-overflow arithmetic of the smoothing stages relies on.

// File: rtl/trend_pkg.sv
package trend_pkg;
  typedef enum logic [0:0] {
    RATE_SLOW = 1'b0,
    RATE_FAST = 1'b1
  } rate_e;

  localparam int STAGES = 3;
endpackage

// File: rtl/trend_ema_stage.sv
module trend_ema_stage
  import trend_pkg::*;
#(
  parameter int    SW         = 30,
  parameter rate_e RATE       = RATE_SLOW,
  parameter int    SLOW_SHIFT = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 seed_en,
  input  logic signed [SW-1:0] seed_val,
  input  logic                 step_en,
  input  logic signed [SW-1:0] x_in,
  output logic signed [SW-1:0] acc_q
);
  logic signed [SW-1:0] gap;
  logic signed [SW-1:0] inc;

  function automatic logic signed [SW-1:0] slow_gain(input logic signed [SW-1:0] d);
    return d >>> SLOW_SHIFT;
  endfunction

  function automatic logic signed [SW-1:0] fast_gain(input logic signed [SW-1:0] d);
    return (d >>> 1) + (d >>> 2) + (d >>> 5) + (d >>> 6);
  endfunction

  assign gap = x_in - acc_q;

  generate
    if (RATE == RATE_SLOW) begin : g_slow
      assign inc = slow_gain(gap);
    end else begin : g_fast
      assign inc = fast_gain(gap);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= '0;
    else if (seed_en) acc_q <= seed_val;
    else if (step_en) acc_q <= acc_q + inc;
  end
endmodule

// File: rtl/trend_channel.sv
module trend_channel
  import trend_pkg::*;
#(
  parameter int    SW   = 30,
  parameter rate_e RATE = RATE_SLOW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 seed_en,
  input  logic [STAGES-1:0]    step_en,
  input  logic signed [SW-1:0] head,
  output logic signed [SW-1:0] trend
);
  logic signed [SW-1:0] stage_in [STAGES];
  logic signed [SW-1:0] stage_q  [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign stage_in[i] = head;
    end else begin : g_link
      assign stage_in[i] = stage_q[i-1];
    end
    trend_ema_stage #(.SW(SW), .RATE(RATE)) u_ema (
      .clk      (clk),
      .rst_n    (rst_n),
      .seed_en  (seed_en),
      .seed_val (head),
      .step_en  (step_en[i]),
      .x_in     (stage_in[i]),
      .acc_q    (stage_q[i])
    );
  end

  assign trend = stage_q[STAGES-1];
endmodule

// File: rtl/trend_drift_compare.sv
module trend_drift_compare #(
  parameter int W    = 16,
  parameter int FRAC = 12,
  parameter int SW   = 30
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 eval_en,
  input  logic signed [SW-1:0] fast_t,
  input  logic signed [SW-1:0] slow_t,
  input  logic [W-1:0]         thresh,
  input  logic                 clr,
  output logic                 over_evt,
  output logic                 out_valid,
  output logic signed [SW-1:0] slow_o,
  output logic signed [SW-1:0] fast_o,
  output logic                 flag
);
  localparam int PAD = SW - W - FRAC;

  logic signed [SW-1:0] spread;
  logic signed [SW-1:0] limit;

  assign spread   = fast_t - slow_t;
  assign limit    = $signed({{PAD{1'b0}}, thresh, {FRAC{1'b0}}});
  assign over_evt = eval_en && (spread > limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      slow_o    <= '0;
      fast_o    <= '0;
      flag      <= 1'b0;
    end else begin
      out_valid <= eval_en;
      if (eval_en) begin
        slow_o <= slow_t;
        fast_o <= fast_t;
      end
      if (clr)           flag <= 1'b0;
      else if (over_evt) flag <= 1'b1;
    end
  end
endmodule

// File: rtl/trend_drift_detector.sv
module trend_drift_detector
  import trend_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 12,
  parameter int SW   = W + FRAC + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [W-1:0]         in_sample,
  input  logic [W-1:0]         thresh,
  input  logic                 flag_clr,
  output logic                 out_valid,
  output logic signed [SW-1:0] slow_trend,
  output logic signed [SW-1:0] fast_trend,
  output logic                 drift_flag
);
  localparam int PAD = SW - W - FRAC;

  logic                 seeded_q;
  logic                 seed_evt;
  logic                 over_evt;
  logic [STAGES:1]      vpipe;
  logic [STAGES-1:0]    step_en;
  logic signed [SW-1:0] head;
  logic signed [SW-1:0] slow_t;
  logic signed [SW-1:0] fast_t;

  assign seed_evt = in_valid && !seeded_q;
  assign head     = $signed({{PAD{1'b0}}, in_sample, {FRAC{1'b0}}});
  assign step_en  = {vpipe[2], vpipe[1], in_valid && seeded_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seeded_q <= 1'b0;
      vpipe    <= '0;
    end else begin
      if (seed_evt) seeded_q <= 1'b1;
      vpipe <= {vpipe[STAGES-1:1], in_valid};
    end
  end

  trend_channel #(.SW(SW), .RATE(RATE_SLOW)) u_slow (
    .clk (clk), .rst_n (rst_n), .seed_en (seed_evt),
    .step_en (step_en), .head (head), .trend (slow_t)
  );

  trend_channel #(.SW(SW), .RATE(RATE_FAST)) u_fast (
    .clk (clk), .rst_n (rst_n), .seed_en (seed_evt),
    .step_en (step_en), .head (head), .trend (fast_t)
  );

  trend_drift_compare #(.W(W), .FRAC(FRAC), .SW(SW)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .eval_en   (vpipe[STAGES]),
    .fast_t    (fast_t),
    .slow_t    (slow_t),
    .thresh    (thresh),
    .clr       (flag_clr),
    .over_evt  (over_evt),
    .out_valid (out_valid),
    .slow_o    (slow_trend),
    .fast_o    (fast_trend),
    .flag      (drift_flag)
  );
endmodule

// File: rtl/trend_drift_checker.sv
module trend_drift_checker #(
  parameter int W    = 16,
  parameter int FRAC = 12,
  parameter int SW   = 30
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [W-1:0]         thresh,
  input logic                 flag_clr,
  input logic                 out_valid,
  input logic signed [SW-1:0] slow_trend,
  input logic signed [SW-1:0] fast_trend,
  input logic                 drift_flag
);
  localparam int PAD = SW - W - FRAC;

  logic signed [SW-1:0] gap_now;
  logic signed [SW-1:0] lim_now;
  assign gap_now = fast_trend - slow_trend;
  assign lim_now = $signed({{PAD{1'b0}}, thresh, {FRAC{1'b0}}});

  // R6
  report_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 4));

  // R6
  hold_between_reports_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(slow_trend) && $stable(fast_trend)));

  // R7
  raise_on_excess_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drift_flag) |-> (out_valid && (gap_now > $past(lim_now))));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drift_flag && !flag_clr) |=> drift_flag);

  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !drift_flag);

  // R9
  no_raise_when_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (gap_now <= 0)) |-> !$rose(drift_flag));
endmodule

bind trend_drift_detector trend_drift_checker #(.W(W), .FRAC(FRAC), .SW(SW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .thresh     (thresh),
  .flag_clr   (flag_clr),
  .out_valid  (out_valid),
  .slow_trend (slow_trend),
  .fast_trend (fast_trend),
  .drift_flag (drift_flag)
);

// File: tb/trend_drift_detector_bench.sv
`timescale 1ns/1ps
module trend_drift_detector_bench;
  localparam int W    = 16;
  localparam int FRAC = 12;
  localparam int SW   = W + FRAC + 2;
  localparam int QN   = 256;

  localparam int NTAB = 6;
  localparam int TAB_SAMPLE [NTAB] = '{100, 100, 120, 400, 400, 100};
  localparam int TAB_THR    [NTAB] = '{200, 200, 200, 200, 200, 200};
  localparam bit TAB_FLAG   [NTAB] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic [W-1:0]         in_sample = '0;
  logic [W-1:0]         thresh = '0;
  logic                 flag_clr = 1'b0;
  logic                 out_valid;
  logic signed [SW-1:0] slow_trend;
  logic signed [SW-1:0] fast_trend;
  logic                 drift_flag;

  always #2 clk = ~clk;

  trend_drift_detector #(.W(W), .FRAC(FRAC)) u_trend_drift_detector (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_sample (in_sample),
    .thresh (thresh), .flag_clr (flag_clr), .out_valid (out_valid),
    .slow_trend (slow_trend), .fast_trend (fast_trend), .drift_flag (drift_flag)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: stage values as plain integers, floor division written out
  longint m_st [2][3];
  bit     m_seeded = 0;
  bit     m_flag   = 0;

  function automatic longint floor_div(input longint d, input int k);
    longint p = longint'(1) << k;
    if (d >= 0) return d / p;
    return -((-d + p - 1) / p);
  endfunction

  function automatic longint gain(input int ch, input longint d);
    if (ch == 0) return floor_div(d, 10);
    return floor_div(d, 1) + floor_div(d, 2) + floor_div(d, 5) + floor_div(d, 6);
  endfunction

  longint q_slow [QN];
  longint q_fast [QN];
  bit     q_flag [QN];
  int     q_cyc  [QN];
  string  q_tag  [QN];
  int     wr = 0;
  int     rd = 0;

  task automatic model_push(input int s, input int thr, input bit clr_out, input string tag);
    longint x = longint'(s) * 4096;
    if (!m_seeded) begin
      m_seeded = 1;
      for (int c = 0; c < 2; c++) for (int j = 0; j < 3; j++) m_st[c][j] = x;
    end else begin
      for (int c = 0; c < 2; c++) begin
        m_st[c][0] = m_st[c][0] + gain(c, x - m_st[c][0]);
        m_st[c][1] = m_st[c][1] + gain(c, m_st[c][0] - m_st[c][1]);
        m_st[c][2] = m_st[c][2] + gain(c, m_st[c][1] - m_st[c][2]);
      end
    end
    if (clr_out) m_flag = 0;
    else if (m_st[1][2] - m_st[0][2] > longint'(thr) * 4096) m_flag = 1;
    q_slow[wr % QN] = m_st[0][2];
    q_fast[wr % QN] = m_st[1][2];
    q_flag[wr % QN] = m_flag;
    q_cyc[wr % QN]  = cyc + 1;
    q_tag[wr % QN]  = tag;
    wr++;
  endtask

  // Output monitor: value, flag and timing of every report; stability between reports
  longint prev_slow = 0;
  longint prev_fast = 0;
  int     unstable  = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (rd == wr) begin
          check(1'b0, "R6 unexpected out_valid", 1, 0);
        end else begin
          check(longint'(slow_trend) == q_slow[rd % QN], {q_tag[rd % QN], " R3 R4 slow"},
                longint'(slow_trend), q_slow[rd % QN]);
          check(longint'(fast_trend) == q_fast[rd % QN], {q_tag[rd % QN], " R3 R5 fast"},
                longint'(fast_trend), q_fast[rd % QN]);
          check(drift_flag == q_flag[rd % QN], {q_tag[rd % QN], " R7 flag"},
                longint'(drift_flag), longint'(q_flag[rd % QN]));
          check(cyc == q_cyc[rd % QN] + 3, {q_tag[rd % QN], " R6 latency"},
                cyc, q_cyc[rd % QN] + 3);
          rd++;
        end
      end else if (longint'(slow_trend) != prev_slow || longint'(fast_trend) != prev_fast) begin
        unstable++;
      end
    end
    prev_slow = longint'(slow_trend);
    prev_fast = longint'(fast_trend);
  end

  task automatic send(input int s, input int thr, input bit clr_out, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_sample = W'(s); thresh = W'(thr);
    model_push(s, thr, clr_out, tag);
    @(negedge clk);
    in_valid = 1'b0;
    if (clr_out) begin
      repeat (2) @(negedge clk);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
    end else begin
      repeat (3) @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; flag_clr = 1'b0;
    m_seeded = 0; m_flag = 0;
    repeat (3) @(negedge clk);
    check(!out_valid && !drift_flag && slow_trend == 0 && fast_trend == 0, "R1 during reset",
          longint'(drift_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 20000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    check(!out_valid, "R1 out_valid after reset", longint'(out_valid), 0);
    check(!drift_flag, "R1 flag after reset", longint'(drift_flag), 0);
    check(slow_trend == 0 && fast_trend == 0, "R1 trends after reset", longint'(slow_trend), 0);

    // Vector table walk: seed, steady, rising latency, flag, sticky
    for (int i = 0; i < NTAB; i++) begin
      send(TAB_SAMPLE[i], TAB_THR[i], 1'b0, (i == 0) ? "R2 seed" : "R7 table");
      if (i == 0) begin
        check(longint'(slow_trend) == 100 * 4096, "R2 slow seeded", longint'(slow_trend), 100 * 4096);
        check(longint'(fast_trend) == 100 * 4096, "R2 fast seeded", longint'(fast_trend), 100 * 4096);
      end
      check(drift_flag == TAB_FLAG[i], (i == 5) ? "R8 sticky table" : "R7 table flag",
            longint'(drift_flag), longint'(TAB_FLAG[i]));
    end

    // Latency drops while the flag is held
    for (int i = 0; i < 6; i++) send(0, 0, 1'b0, "R8 hold");
    check(drift_flag, "R8 flag held through low samples", longint'(drift_flag), 1);

    // Standalone clear with no sample in flight
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0; m_flag = 0;
    check(!drift_flag, "R8 clear", longint'(drift_flag), 0);

    // Fast below slow with a zero limit
    for (int i = 0; i < 4; i++) send(0, 0, 1'b0, "R9 below");
    check(!drift_flag, "R9 no flag when fast below slow", longint'(drift_flag), 0);
    check(fast_trend < slow_trend, "R9 fast below slow", longint'(fast_trend), longint'(slow_trend));

    // Clear arriving on the same edge as a set condition
    send(400, 10, 1'b1, "R8 clear priority");
    check(!drift_flag, "R8 clear wins over set", longint'(drift_flag), 0);
    send(400, 10, 1'b0, "R7 set again");
    check(drift_flag, "R7 set after clear", longint'(drift_flag), 1);

    // Reset mid-run, then back-to-back strobes
    do_reset();
    check(!drift_flag && slow_trend == 0, "R1 reset clears flag and state", longint'(drift_flag), 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sample = W'(10 * (i + 1)); thresh = W'(1000);
      model_push(10 * (i + 1), 1000, 1'b0, "R10 burst");
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (6) @(negedge clk);
    check(rd == wr, "R10 every burst strobe reported", rd, wr);
    check(unstable == 0, "R6 outputs stable between reports", unstable, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule